// File: doc/BRIEF.md
# Note Duration Counter with Table Reload

This block measures how long one tone channel keeps sounding. A write to the channel's high timer byte loads the counter with an 8-bit duration. A 5-bit index, taken from the upper bits of that byte, selects the duration from a fixed and irregular 32-entry table. The counter then counts down by one on each half-frame strobe from the frame sequencer. The channel logic uses the `active` output as a gate: the note is audible only while the count is nonzero.

A halt input freezes the countdown, so a note can be held indefinitely. Turning the channel off forces the count to zero at the next clock edge. While the channel stays off, it also blocks any new load. Waveform generation lives elsewhere. This block gives only the duration state.

Top module: `note_len_counter`

## Requirements
- R1: After reset, `count` is 0 and `active` is 0.
- R2: With `chan_en` high, a `load_stb` makes `count` equal, one cycle later, to table[`load_byte[7:3]`]. The table for indices 0 to 31 is 10,254,20,2,40,4,80,6,160,8,60,10,14,12,26,14,12,16,24,18,48,20,96,22,192,24,72,26,16,28,32,30.
- R3: With `chan_en` high, no load, `halt` low and `count` nonzero, a `half_stb` lowers `count` by exactly 1 at the next edge.
- R4: While `halt` is high, a `half_stb` leaves `count` unchanged.
- R5: When `count` is 0, a `half_stb` leaves it at 0. It never wraps.
- R6: When `chan_en` is low in a cycle, `count` is 0 after that cycle's edge, whatever the other inputs are.
- R7: A `load_stb` while `chan_en` is low is ignored, and `count` stays 0.
- R8: If `load_stb` and `half_stb` occur in the same enabled cycle, the load wins, and `count` becomes the table value with no decrement.
- R9: `active` is 1 exactly when `count` is nonzero.
- R10: In an enabled cycle with neither strobe, `count` does not change.
- R11: Bits 2:0 of `load_byte` have no effect on the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable. Low clears the count and blocks loads |
| halt | input | 1 | High freezes the countdown |
| load_stb | input | 1 | One-cycle strobe: the high timer byte was written |
| load_byte | input | 8 | Written byte. Bits 7:3 select the table entry |
| half_stb | input | 1 | One-cycle half-frame strobe from the frame sequencer |
| active | output | 1 | High while the count is nonzero |
| count | output | 8 | Current remaining duration |

## Verification
Every piece of state in this block is visible directly on `count`, so any wrong internal value shows up on the port one cycle after the edge that produced it. A wrong table entry appears right after a load of that index. A wrong priority appears in the single cycle where a load coincides with a strobe or with a disable. A decrement that wraps or ignores `halt` shows up on the very next strobe, and `active` exposes a zero/nonzero mismatch in that same cycle.

// File: rtl/notelen_pkg.sv
package notelen_pkg;

   localparam int NL_IDX_W = 5;
   localparam int NL_VAL_W = 8;
   localparam int NL_DEPTH = 1 << NL_IDX_W;

   // Duration for a table index, derived arithmetically.
   // Odd indices give index-1, except index 1, which gives 254.
   // Even indices form two rows of eight, selected by bit 4 with base 10 or 12.
   function automatic logic [NL_VAL_W-1:0] nl_duration(input logic [NL_IDX_W-1:0] idx);
      logic [NL_VAL_W-1:0] base;
      logic [2:0]          col;
      logic [NL_VAL_W-1:0] res;
      base = idx[4] ? 8'd12 : 8'd10;
      col  = idx[3:1];
      if (idx[0]) begin
         res = (idx == 5'd1) ? 8'd254 : {3'b000, idx} - 8'd1;
      end else begin
         case (col)
            3'd5:    res = idx[4] ? 8'd72 : 8'd60;
            3'd6:    res = idx[4] ? 8'd16 : 8'd14;
            3'd7:    res = idx[4] ? 8'd32 : 8'd26;
            default: res = base << col;
         endcase
      end
      return res;
   endfunction

endpackage

// File: rtl/notelen_rom.sv
module notelen_rom
   import notelen_pkg::*;
#(
   parameter int IDX_W     = NL_IDX_W,
   parameter int VAL_W     = NL_VAL_W,
   parameter int ROM_STYLE = 0   // 0: explicit case mux, 1: arithmetic decode
) (
   input  logic [IDX_W-1:0] idx,
   output logic [VAL_W-1:0] dur
);

   if (IDX_W != NL_IDX_W) begin : g_bad_idx
      $error("notelen_rom: IDX_W must be %0d", NL_IDX_W);
   end
   if (VAL_W != NL_VAL_W) begin : g_bad_val
      $error("notelen_rom: VAL_W must be %0d", NL_VAL_W);
   end
   if (ROM_STYLE != 0 && ROM_STYLE != 1) begin : g_bad_style
      $error("notelen_rom: ROM_STYLE must be 0 or 1");
   end

   if (ROM_STYLE == 0) begin : g_case
      always_comb begin
         case (idx)
            5'd0:  dur = 8'd10;   5'd1:  dur = 8'd254;
            5'd2:  dur = 8'd20;   5'd3:  dur = 8'd2;
            5'd4:  dur = 8'd40;   5'd5:  dur = 8'd4;
            5'd6:  dur = 8'd80;   5'd7:  dur = 8'd6;
            5'd8:  dur = 8'd160;  5'd9:  dur = 8'd8;
            5'd10: dur = 8'd60;   5'd11: dur = 8'd10;
            5'd12: dur = 8'd14;   5'd13: dur = 8'd12;
            5'd14: dur = 8'd26;   5'd15: dur = 8'd14;
            5'd16: dur = 8'd12;   5'd17: dur = 8'd16;
            5'd18: dur = 8'd24;   5'd19: dur = 8'd18;
            5'd20: dur = 8'd48;   5'd21: dur = 8'd20;
            5'd22: dur = 8'd96;   5'd23: dur = 8'd22;
            5'd24: dur = 8'd192;  5'd25: dur = 8'd24;
            5'd26: dur = 8'd72;   5'd27: dur = 8'd26;
            5'd28: dur = 8'd16;   5'd29: dur = 8'd28;
            5'd30: dur = 8'd32;   default: dur = 8'd30;
         endcase
      end
   end else begin : g_arith
      always_comb dur = nl_duration(idx);
   end

endmodule

// File: rtl/notelen_core.sv
module notelen_core #(
   parameter int VAL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             halt,
   input  logic             load_stb,
   input  logic [VAL_W-1:0] load_val,
   input  logic             half_stb,
   output logic [VAL_W-1:0] cnt_q
);

   if (VAL_W < 1) begin : g_bad_w
      $error("notelen_core: VAL_W must be positive");
   end

   logic             can_dec;
   logic [VAL_W-1:0] cnt_d;

   assign can_dec = half_stb && !halt && (cnt_q != '0);

   always_comb begin
      cnt_d = cnt_q;
      if (!chan_en)      cnt_d = '0;
      else if (load_stb) cnt_d = load_val;
      else if (can_dec)  cnt_d = cnt_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> cnt_q == '0);                                            // R6
   AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en && load_stb |=> cnt_q == $past(load_val));                   // R8
   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en && !load_stb && half_stb && !halt && cnt_q != '0
      |=> cnt_q == $past(cnt_q) - 1'b1);                                    // R3
   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en && !load_stb && halt |=> $stable(cnt_q));                     // R4
   AST_ZERO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      !load_stb && cnt_q == '0 |=> cnt_q == '0);                            // R5
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en && !load_stb && !half_stb |=> $stable(cnt_q));                // R10

endmodule

// File: rtl/note_len_counter.sv
module note_len_counter
   import notelen_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int IDX_LSB   = 3,
   parameter int ROM_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              halt,
   input  logic              load_stb,
   input  logic [BYTE_W-1:0] load_byte,
   input  logic              half_stb,
   output logic              active,
   output logic [NL_VAL_W-1:0] count
);

   localparam int IDX_MSB = IDX_LSB + NL_IDX_W - 1;

   if (IDX_MSB >= BYTE_W) begin : g_bad_field
      $error("note_len_counter: index field does not fit in load byte");
   end

   logic [NL_IDX_W-1:0] tbl_idx;
   logic [NL_VAL_W-1:0] tbl_val;
   logic                unused_low;

   assign tbl_idx    = load_byte[IDX_MSB:IDX_LSB];
   assign unused_low = ^load_byte[IDX_LSB-1:0];   // R11: low bits do not select

   notelen_rom #(
      .IDX_W     (NL_IDX_W),
      .VAL_W     (NL_VAL_W),
      .ROM_STYLE (ROM_STYLE)
   ) u_rom (
      .idx (tbl_idx),
      .dur (tbl_val)
   );

   notelen_core #(
      .VAL_W (NL_VAL_W)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .chan_en  (chan_en),
      .halt     (halt),
      .load_stb (load_stb),
      .load_val (tbl_val),
      .half_stb (half_stb),
      .cnt_q    (count)
   );

   assign active = |count;

   AST_LOAD_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en && load_stb |=> count == nl_duration($past(tbl_idx)));        // R2
   AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en && load_stb |=> !active);                                     // R7
   AST_ACTIVE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      active == (count != '0));                                              // R9

endmodule

// File: tb/tb_note_len_counter.sv
`timescale 1ns/1ps
module tb_note_len_counter;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       chan_en, halt, load_stb, half_stb;
   logic [7:0] load_byte;
   logic       active;
   logic [7:0] count;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_cnt;
   bit done = 0;

   always #4 clk = ~clk;

   note_len_counter dut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .halt(halt),
      .load_stb(load_stb), .load_byte(load_byte), .half_stb(half_stb),
      .active(active), .count(count)
   );

   function automatic logic [7:0] ref_dur(input logic [4:0] i);
      logic [7:0] t [32] = '{8'd10,8'd254,8'd20,8'd2,8'd40,8'd4,8'd80,8'd6,
                              8'd160,8'd8,8'd60,8'd10,8'd14,8'd12,8'd26,8'd14,
                              8'd12,8'd16,8'd24,8'd18,8'd48,8'd20,8'd96,8'd22,
                              8'd192,8'd24,8'd72,8'd26,8'd16,8'd28,8'd32,8'd30};
      return t[i];
   endfunction

   function automatic logic [7:0] ref_next(input logic [7:0] c, input bit en, input bit h,
                                           input bit ld, input logic [7:0] b, input bit hs);
      if (!en)                   return 8'd0;
      if (ld)                    return ref_dur(b[7:3]);
      if (hs && !h && c != 8'd0) return c - 8'd1;
      return c;
   endfunction

   task automatic check(input string tag);
      checks++;
      if (count !== exp_cnt) begin
         errors++;
         $display("FAIL %s count actual %0d expected %0d", tag, count, exp_cnt);
      end
      checks++;
      if (active !== (exp_cnt != 8'd0)) begin
         errors++;
         $display("FAIL R9 (%s) active actual %0b expected %0b", tag, active, exp_cnt != 8'd0);
      end
   endtask

   task automatic step(input bit en, input bit h, input bit ld, input logic [7:0] b,
                       input bit hs, input string tag);
      @(negedge clk);
      chan_en = en; halt = h; load_stb = ld; load_byte = b; half_stb = hs;
      exp_cnt = ref_next(exp_cnt, en, h, ld, b, hs);
      @(posedge clk); #1;
      check(tag);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 0; chan_en = 0; halt = 0; load_stb = 0; load_byte = 0; half_stb = 0;
      exp_cnt = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R1");
      @(negedge clk) rst_n = 1;

      // R2 / R11: every index, with the low bits varied
      for (int i = 0; i < 32; i++) begin
         step(1, 0, 1, {i[4:0], 3'($urandom)}, 0, "R2");
         step(1, 0, 1, {i[4:0], 3'b111 ^ 3'(i)}, 0, "R11");
      end
      // R3: count down from 2 to 0, then R5 floor
      step(1, 0, 1, {5'd3, 3'd0}, 0, "R2");
      step(1, 0, 0, 8'h00, 1, "R3");
      step(1, 0, 0, 8'h00, 1, "R3");
      step(1, 0, 0, 8'h00, 1, "R5");
      step(1, 0, 0, 8'h00, 1, "R5");
      // R4: halt holds
      step(1, 0, 1, {5'd0, 3'd5}, 0, "R2");
      step(1, 1, 0, 8'h00, 1, "R4");
      step(1, 1, 0, 8'h00, 1, "R4");
      // R10: idle cycles
      step(1, 0, 0, 8'h00, 0, "R10");
      // R8: load beats strobe
      step(1, 0, 1, {5'd1, 3'd0}, 1, "R8");
      // R6: disable clears
      step(0, 0, 0, 8'h00, 1, "R6");
      // R7: load while off ignored
      step(0, 0, 1, {5'd8, 3'd0}, 0, "R7");
      step(0, 1, 1, {5'd24, 3'd0}, 1, "R7");
      // R6: disable wins over load from a nonzero count
      step(1, 0, 1, {5'd24, 3'd0}, 0, "R2");
      step(0, 0, 1, {5'd24, 3'd0}, 0, "R6");

      // random mix
      for (int n = 0; n < 4000; n++) begin
         bit en, h, ld, hs;
         en = ($urandom % 16) != 0;
         h  = ($urandom % 5) == 0;
         ld = ($urandom % 12) == 0;
         hs = ($urandom % 3) == 0;
         step(en, h, ld, 8'($urandom), hs,
              !en ? "R6" : ld ? "R8" : (hs && !h) ? "R3" : "R10");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule